// File: doc/BRIEF.md
# Timer Output Compare Unit

This block is an up-counting timer with one compare channel. It runs on the system clock. The counter advances only on cycles where an internal timer tick is asserted. A prescaler produces that tick, either on every system clock or at a divided rate, and a 3-bit select field chooses the rate. A comparator checks the counter against a compare register. When the two are equal on a tick, a compare flag is set. An overflow flag is set when the counter rolls over from its all-ones value to zero. Each flag drives a level interrupt request while its enable input is high.

The CPU side has five write strobes: one loads the counter, one loads the compare register, and one clears flags by writing a one to the flag's bit. The last two acknowledge the compare interrupt and the overflow interrupt, and each acknowledge clears its flag. A counter load arms a one-shot block. The block suppresses any compare match on the next tick, whether that tick comes one cycle later or many cycles later after the timer was stopped. The block exists so that software can set the counter and the compare register to the same value and start the timer without receiving a match at once.

Top module: `tmr_cmp_unit`

## Requirements
- R1: On a tick cycle with no counter write and no armed block, if the counter equals the compare register, the compare flag reads 1 from the next cycle on.
- R2: The compare request `cmp_irq` is high exactly while the compare flag and `cmp_ie` are both high. The overflow request `ovf_irq` is high exactly while the overflow flag and `ovf_ie` are both high.
- R3: A pulse on `cmp_ack` clears the compare flag on the next edge. A pulse on `ovf_ack` clears the overflow flag on the next edge.
- R4: With `sts_clr_wr` high, bit 0 of `sts_clr_bits` clears the compare flag and bit 1 clears the overflow flag. A bit written as zero leaves its flag unchanged.
- R5: A counter write loads `cnt_wdata` at the next edge and arms a block. The next tick consumes the block, and no compare match is taken on that tick, even when the timer was stopped for several cycles between the write and the tick.
- R6: The block covers only one tick. A match on the following tick sets the flag as usual.
- R7: Each tick adds one to the counter. A tick at all-ones wraps the counter to zero and sets the overflow flag.
- R8: Values of `cs_sel`: 0 stops the timer, 1 ticks every cycle, 2 divides by 8, 3 by 64, 4 by 256, 5 by 1024, and 6 and 7 stop the timer. Over any window of N cycles that is a multiple of the divisor, exactly N/divisor ticks occur.
- R9: When a hardware flag set and a clear (write-one or acknowledge) fall in the same cycle, the flag ends up set.
- R10: After reset the counter, the compare register, both flags and both requests are zero.
- R11: When a counter write and a tick fall in the same cycle, the write wins: the counter takes the written value and that tick sets no compare flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_sel | input | 3 | Prescaler select code |
| cnt_wr | input | 1 | Counter write strobe |
| cnt_wdata | input | CNT_W | Counter write value |
| cmp_wr | input | 1 | Compare register write strobe |
| cmp_wdata | input | CNT_W | Compare register write value |
| sts_clr_wr | input | 1 | Flag clear strobe |
| sts_clr_bits | input | 2 | Flags to clear: bit 0 compare, bit 1 overflow |
| cmp_ie | input | 1 | Compare interrupt enable |
| ovf_ie | input | 1 | Overflow interrupt enable |
| cmp_ack | input | 1 | Compare interrupt acknowledge |
| ovf_ack | input | 1 | Overflow interrupt acknowledge |
| cnt_val | output | CNT_W | Current counter value |
| cmp_val | output | CNT_W | Current compare register value |
| cmp_flag | output | 1 | Compare flag |
| ovf_flag | output | 1 | Overflow flag |
| cmp_irq | output | 1 | Compare interrupt request |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
Two pairs of events can meet in one cycle. The first pair is a compare match and a flag clear. The bench places a write-one clear on the edge where the counter leaves the compare value, and it passes only if the flag still reads 1 afterwards. The second pair is a counter write and a running tick. The bench writes the counter in the cycle where the counter already equals the compare value, and it passes only if the counter shows the written value and the flag stays clear.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int PS_W   = 10;
    localparam int NFLG   = 2;
    localparam int FLG_CMP = 0;
    localparam int FLG_OVF = 1;

    typedef enum logic [2:0] {
        CS_STOP    = 3'd0,
        CS_DIV1    = 3'd1,
        CS_DIV8    = 3'd2,
        CS_DIV64   = 3'd3,
        CS_DIV256  = 3'd4,
        CS_DIV1024 = 3'd5
    } cs_code_e;

    typedef struct packed {
        logic hit;
        logic clr;
    } flag_evt_t;

    // Low prescaler bits that must all be ones for a divided tick.
    function automatic logic [PS_W-1:0] ps_mask(input logic [2:0] sel);
        logic [PS_W-1:0] m;
        case (sel)
            CS_DIV8:    m = PS_W'(10'h007);
            CS_DIV64:   m = PS_W'(10'h03F);
            CS_DIV256:  m = PS_W'(10'h0FF);
            CS_DIV1024: m = PS_W'(10'h3FF);
            default:    m = '0;
        endcase
        return m;
    endfunction

    function automatic logic ps_tick(input logic [2:0] sel, input logic [PS_W-1:0] ps);
        logic t;
        case (sel)
            CS_DIV1:                            t = 1'b1;
            CS_DIV8, CS_DIV64, CS_DIV256,
            CS_DIV1024:                         t = ((ps & ps_mask(sel)) == ps_mask(sel));
            default:                            t = 1'b0;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] sel,
    output logic       tick
);
    logic [PS_W-1:0] ps_q;

    always_ff @(posedge clk) begin
        if (rst) ps_q <= '0;
        else     ps_q <= ps_q + 1'b1;
    end

    always_comb tick = ps_tick(sel, ps_q);

endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cmp,
    output logic             blk_pend,
    output logic             cmp_hit,
    output logic             ovf_hit
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic adv;

    always_comb begin
        adv     = tick && !cnt_wr;
        cmp_hit = adv && !blk_pend && (cnt == cmp);
        ovf_hit = adv && (cnt == CNT_MAX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            blk_pend <= 1'b0;
        end else if (cnt_wr) begin
            cnt      <= cnt_wdata;
            blk_pend <= 1'b1;
        end else if (tick) begin
            cnt      <= cnt + 1'b1;
            blk_pend <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         cmp <= '0;
        else if (cmp_wr) cmp <= cmp_wdata;
    end

endmodule

// File: rtl/tmr_flag.sv
module tmr_flag
    import tmr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  flag_evt_t evt,
    input  logic      ie,
    output logic      flag,
    output logic      irq
);
    always_ff @(posedge clk) begin
        if (rst)          flag <= 1'b0;
        else if (evt.hit) flag <= 1'b1;
        else if (evt.clr) flag <= 1'b0;
    end

    always_comb irq = flag && ie;

endmodule

// File: rtl/tmr_cmp_unit.sv
module tmr_cmp_unit
    import tmr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       cs_sel,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             sts_clr_wr,
    input  logic [1:0]       sts_clr_bits,
    input  logic             cmp_ie,
    input  logic             ovf_ie,
    input  logic             cmp_ack,
    input  logic             ovf_ack,
    output logic [CNT_W-1:0] cnt_val,
    output logic [CNT_W-1:0] cmp_val,
    output logic             cmp_flag,
    output logic             ovf_flag,
    output logic             cmp_irq,
    output logic             ovf_irq
);
    logic            tick;
    logic            blk_pend;
    logic            cmp_hit;
    logic            ovf_hit;
    flag_evt_t       evt   [NFLG];
    logic [NFLG-1:0] ie_v;
    logic [NFLG-1:0] ack_v;
    logic [NFLG-1:0] hit_v;
    logic [NFLG-1:0] flag_v;
    logic [NFLG-1:0] irq_v;

    tmr_prescaler u_ps (
        .clk  (clk),
        .rst  (rst),
        .sel  (cs_sel),
        .tick (tick)
    );

    tmr_count #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (cnt_wdata),
        .cmp_wr    (cmp_wr),
        .cmp_wdata (cmp_wdata),
        .cnt       (cnt_val),
        .cmp       (cmp_val),
        .blk_pend  (blk_pend),
        .cmp_hit   (cmp_hit),
        .ovf_hit   (ovf_hit)
    );

    always_comb begin
        hit_v[FLG_CMP] = cmp_hit;
        hit_v[FLG_OVF] = ovf_hit;
        ack_v[FLG_CMP] = cmp_ack;
        ack_v[FLG_OVF] = ovf_ack;
        ie_v[FLG_CMP]  = cmp_ie;
        ie_v[FLG_OVF]  = ovf_ie;
    end

    for (genvar i = 0; i < NFLG; i++) begin : g_flag
        always_comb begin
            evt[i].hit = hit_v[i];
            evt[i].clr = ack_v[i] || (sts_clr_wr && sts_clr_bits[i]);
        end

        tmr_flag u_flag (
            .clk  (clk),
            .rst  (rst),
            .evt  (evt[i]),
            .ie   (ie_v[i]),
            .flag (flag_v[i]),
            .irq  (irq_v[i])
        );
    end

    always_comb begin
        cmp_flag = flag_v[FLG_CMP];
        ovf_flag = flag_v[FLG_OVF];
        cmp_irq  = irq_v[FLG_CMP];
        ovf_irq  = irq_v[FLG_OVF];
    end

endmodule

// File: rtl/tmr_cmp_chk.sv
module tmr_cmp_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       cs_sel,
    input logic             tick,
    input logic             blk_pend,
    input logic             cnt_wr,
    input logic [CNT_W-1:0] cnt_wdata,
    input logic             sts_clr_wr,
    input logic [1:0]       sts_clr_bits,
    input logic             cmp_ack,
    input logic [CNT_W-1:0] cnt_val,
    input logic [CNT_W-1:0] cmp_val,
    input logic             cmp_flag,
    input logic             ovf_flag
);
    AST_MATCH_SETS: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_wr && !blk_pend && cnt_val == cmp_val) |=> cmp_flag); // R1

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (cmp_ack && !tick) |=> !cmp_flag); // R3

    AST_W1C_OVF: assert property (@(posedge clk) disable iff (rst)
        (sts_clr_wr && sts_clr_bits[1] && !tick) |=> !ovf_flag); // R4

    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> (cnt_val == $past(cnt_wdata) && blk_pend)); // R5

    AST_BLOCKED_TICK: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_wr && blk_pend && !cmp_flag) |=> !cmp_flag); // R5

    AST_NO_OVERFLOW_MISS: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_wr && cnt_val == '1) |=> (ovf_flag && cnt_val == '0)); // R7

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!tick && !cnt_wr) |=> $stable(cnt_val)); // R7

    AST_STOP_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (cs_sel == 3'd0 || cs_sel >= 3'd6) |-> !tick); // R8

endmodule

bind tmr_cmp_unit tmr_cmp_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cs_sel       (cs_sel),
    .tick         (tick),
    .blk_pend     (blk_pend),
    .cnt_wr       (cnt_wr),
    .cnt_wdata    (cnt_wdata),
    .sts_clr_wr   (sts_clr_wr),
    .sts_clr_bits (sts_clr_bits),
    .cmp_ack      (cmp_ack),
    .cnt_val      (cnt_val),
    .cmp_val      (cmp_val),
    .cmp_flag     (cmp_flag),
    .ovf_flag     (ovf_flag)
);

// File: tb/tmr_cmp_unit_tb_top.sv
module tmr_cmp_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic [2:0]   cs_sel;
    logic         cnt_wr;
    logic [W-1:0] cnt_wdata;
    logic         cmp_wr;
    logic [W-1:0] cmp_wdata;
    logic         sts_clr_wr;
    logic [1:0]   sts_clr_bits;
    logic         cmp_ie, ovf_ie, cmp_ack, ovf_ack;
    logic [W-1:0] cnt_val, cmp_val;
    logic         cmp_flag, ovf_flag, cmp_irq, ovf_irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_cmp_unit #(.CNT_W(W)) dut_i (
        .clk(clk), .rst(rst), .cs_sel(cs_sel),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
        .sts_clr_wr(sts_clr_wr), .sts_clr_bits(sts_clr_bits),
        .cmp_ie(cmp_ie), .ovf_ie(ovf_ie), .cmp_ack(cmp_ack), .ovf_ack(ovf_ack),
        .cnt_val(cnt_val), .cmp_val(cmp_val),
        .cmp_flag(cmp_flag), .ovf_flag(ovf_flag),
        .cmp_irq(cmp_irq), .ovf_irq(ovf_irq)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_cnt(input int v);
        cnt_wr = 1'b1; cnt_wdata = W'(v);
        step(1);
        cnt_wr = 1'b0;
    endtask

    task automatic wr_cmp(input int v);
        cmp_wr = 1'b1; cmp_wdata = W'(v);
        step(1);
        cmp_wr = 1'b0;
    endtask

    task automatic clr(input logic [1:0] b);
        sts_clr_wr = 1'b1; sts_clr_bits = b;
        step(1);
        sts_clr_wr = 1'b0; sts_clr_bits = 2'b00;
    endtask

    task automatic t_reset();
        chk("R10", "cnt", int'(cnt_val), 0);
        chk("R10", "cmp", int'(cmp_val), 0);
        chk("R10", "flags", int'({cmp_flag, ovf_flag}), 0);
        chk("R10", "irqs", int'({cmp_irq, ovf_irq}), 0);
    endtask

    task automatic t_match_irq_ack();
        cs_sel = 3'd0;
        wr_cmp(10); wr_cnt(5); clr(2'b11);
        cs_sel = 3'd1;
        step(5);
        chk("R7", "cnt after 5 ticks", int'(cnt_val), 10);
        chk("R1", "flag before match tick", int'(cmp_flag), 0);
        step(1);
        chk("R1", "flag after match tick", int'(cmp_flag), 1);
        chk("R2", "irq with enable low", int'(cmp_irq), 0);
        cs_sel = 3'd0;
        cmp_ie = 1'b1; #1;
        chk("R2", "irq with enable high", int'(cmp_irq), 1);
        cmp_ack = 1'b1; step(1); cmp_ack = 1'b0;
        chk("R3", "flag after ack", int'(cmp_flag), 0);
        chk("R2", "irq after ack", int'(cmp_irq), 0);
        cmp_ie = 1'b0;
    endtask

    task automatic t_w1c();
        cs_sel = 3'd0;
        wr_cmp(30); wr_cnt(29); clr(2'b11);
        cs_sel = 3'd1; step(2); cs_sel = 3'd0;
        chk("R1", "flag set for w1c test", int'(cmp_flag), 1);
        clr(2'b10);
        chk("R4", "cmp flag after zero bit", int'(cmp_flag), 1);
        clr(2'b01);
        chk("R4", "cmp flag after one bit", int'(cmp_flag), 0);
    endtask

    task automatic t_block_stopped();
        cs_sel = 3'd0;
        wr_cmp(20); wr_cnt(20); clr(2'b11);
        step(3);
        cs_sel = 3'd1;
        step(1);
        chk("R5", "cnt after blocked tick", int'(cnt_val), 21);
        chk("R5", "flag after blocked tick", int'(cmp_flag), 0);
        step(1);
        cs_sel = 3'd0;
        chk("R5", "flag one tick later", int'(cmp_flag), 0);
    endtask

    task automatic t_block_once();
        cs_sel = 3'd0;
        wr_cmp(20); wr_cnt(19); clr(2'b11);
        cs_sel = 3'd1;
        step(1);
        chk("R6", "flag after consuming tick", int'(cmp_flag), 0);
        step(1);
        cs_sel = 3'd0;
        chk("R6", "match on following tick", int'(cmp_flag), 1);
        clr(2'b11);
    endtask

    task automatic t_block_running();
        cs_sel = 3'd0;
        wr_cnt(0); wr_cmp(50); clr(2'b11);
        cs_sel = 3'd1;
        step(3);
        wr_cnt(50);
        chk("R5", "cnt loaded while running", int'(cnt_val), 50);
        step(1);
        cs_sel = 3'd0;
        chk("R5", "cnt after running block", int'(cnt_val), 51);
        chk("R5", "flag after running block", int'(cmp_flag), 0);
    endtask

    task automatic t_write_vs_tick();
        cs_sel = 3'd0;
        wr_cmp(40); wr_cnt(39); clr(2'b11);
        cs_sel = 3'd1;
        step(1);
        chk("R11", "cnt at compare value", int'(cnt_val), 40);
        wr_cnt(100);
        cs_sel = 3'd0;
        chk("R11", "write wins over tick", int'(cnt_val), 100);
        chk("R11", "no match on write cycle", int'(cmp_flag), 0);
    endtask

    task automatic t_overflow();
        cs_sel = 3'd0;
        wr_cmp(10); wr_cnt(254); clr(2'b11);
        cs_sel = 3'd1;
        step(1);
        chk("R7", "cnt at max", int'(cnt_val), 255);
        chk("R7", "ovf before wrap", int'(ovf_flag), 0);
        step(1);
        cs_sel = 3'd0;
        chk("R7", "cnt wrapped", int'(cnt_val), 0);
        chk("R7", "ovf after wrap", int'(ovf_flag), 1);
        ovf_ie = 1'b1; #1;
        chk("R2", "ovf irq", int'(ovf_irq), 1);
        clr(2'b01);
        chk("R4", "ovf kept on zero bit", int'(ovf_flag), 1);
        ovf_ack = 1'b1; step(1); ovf_ack = 1'b0;
        chk("R3", "ovf after ack", int'(ovf_flag), 0);
        ovf_ie = 1'b0;
    endtask

    task automatic t_presc(input logic [2:0] sel, input int win, input int exp);
        int c0;
        cs_sel = 3'd0;
        step(1);
        c0 = int'(cnt_val);
        cs_sel = sel;
        step(win);
        cs_sel = 3'd0;
        chk("R8", $sformatf("ticks sel=%0d", sel), (int'(cnt_val) - c0 + 256) % 256, exp);
    endtask

    task automatic t_set_wins();
        cs_sel = 3'd0;
        wr_cmp(10); wr_cnt(9); clr(2'b11);
        cs_sel = 3'd1;
        step(1);
        sts_clr_wr = 1'b1; sts_clr_bits = 2'b01; cmp_ack = 1'b1;
        step(1);
        sts_clr_wr = 1'b0; sts_clr_bits = 2'b00; cmp_ack = 1'b0;
        cs_sel = 3'd0;
        chk("R9", "set beats clear", int'(cmp_flag), 1);
        clr(2'b11);
    endtask

    initial begin
        rst = 1'b1; cs_sel = 3'd0; cnt_wr = 1'b0; cnt_wdata = '0;
        cmp_wr = 1'b0; cmp_wdata = '0; sts_clr_wr = 1'b0; sts_clr_bits = 2'b00;
        cmp_ie = 1'b0; ovf_ie = 1'b0; cmp_ack = 1'b0; ovf_ack = 1'b0;
        step(3);
        rst = 1'b0;
        step(1);
        t_reset();
        t_match_irq_ack();
        t_w1c();
        t_block_stopped();
        t_block_once();
        t_block_running();
        t_write_vs_tick();
        t_overflow();
        t_set_wins();
        t_presc(3'd1, 37, 37);
        t_presc(3'd2, 64, 8);
        t_presc(3'd3, 128, 2);
        t_presc(3'd4, 512, 2);
        t_presc(3'd5, 2048, 2);
        t_presc(3'd6, 40, 0);
        t_presc(3'd7, 40, 0);
        t_presc(3'd0, 40, 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule